// File: doc/BRIEF.md
# Interleaved Wavefront Issue Scheduler

This block decides, every clock, which resident wavefront feeds a narrow SIMD datapath and which slice of its threads goes in. A wavefront holds 64 threads; the datapath has 16 lanes, arranged as four 2x2 quads. One instruction of a wavefront therefore takes four lane-group issues. Two issue positions take turns cycle by cycle. Each of the two interleaved wavefronts issues a lane group every other clock, so the pair completes one instruction each in 8 clocks. This spacing covers the latency of the arithmetic pipeline.

New wavefronts enter through a valid/ready port that states how many general-purpose registers they need. Entry is refused while the register file cannot cover the request or while every resident slot is taken. When the last lane group of an instruction issues, the instruction source reports whether the instruction was a memory access or the final one. A memory access parks the wavefront until a response tagged with its slot number arrives. The freed position is refilled on its next turn by the longest-resident ready wavefront. A finished wavefront returns its slot and registers one cycle later. A turn with nothing to issue is counted as a bubble.

Top module: `wave_issue_sched`

## Requirements
- R1: While reset is low and in the first cycle after it, `iss_valid_o` is 0, `bubble_cnt_o` is 0, and a request of 0 registers sees `adm_ready_o`=1 with `adm_slot_o`=0.
- R2: `adm_ready_o` is 1 exactly when some slot is empty and `adm_gprs_i` plus the registers held by resident wavefronts is at most `RF_SIZE`. A full set of slots therefore refuses even a request of 0 registers.
- R3: An accepted wavefront takes the lowest-numbered empty slot, which `adm_slot_o` shows during the handshake. The wavefront is eligible for issue from the next cycle.
- R4: Once a wavefront holds an issue position, it issues on every second clock. Its lane groups go 0,1,2,3 and then wrap to 0 for the next instruction. `iss_group_o`=g selects threads 16g to 16g+15.
- R5: With two or more wavefronts resident and none stalled, `iss_valid_o` is 1 on every clock. Consecutive issues come from different wavefronts, and each of the two wavefronts gets half the issues.
- R6: `iss_mem_i` and `iss_end_i` are looked at only in a cycle that issues group 3; `iss_end_i` wins if both are high. When `iss_mem_i` is taken, that wavefront issues nothing until `rsp_valid_i` arrives with `rsp_wave_i` equal to its slot. It can issue group 0 in the cycle right after that response.
- R7: A response whose slot is not waiting on memory is ignored. An empty slot that receives one stays empty.
- R8: A free issue position, on its turn, takes the ready wavefront that was admitted earliest, whatever its slot number.
- R9: `bubble_cnt_o` rises by one on each clock whose turn has no issue, and holds otherwise.
- R10: A wavefront whose group 3 issues with `iss_end_i`=1 frees its slot and its registers on the second following clock edge.
- R11: A release and an admission at the same clock edge are both counted in the register total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| adm_valid_i | input | 1 | A new wavefront is offered |
| adm_ready_o | output | 1 | The offered wavefront fits and a slot is free |
| adm_gprs_i | input | $clog2(RF_SIZE+1) | Registers the offered wavefront needs |
| adm_slot_o | output | $clog2(NUM_SLOTS) | Slot the offered wavefront will occupy |
| iss_valid_o | output | 1 | A lane group issues this cycle |
| iss_wave_o | output | $clog2(NUM_SLOTS) | Slot of the issuing wavefront |
| iss_group_o | output | $clog2(WAVE_THREADS/LANES) | Lane group of the issuing wavefront |
| iss_mem_i | input | 1 | The instruction finishing its last group is a memory access |
| iss_end_i | input | 1 | The instruction finishing its last group ends the wavefront |
| rsp_valid_i | input | 1 | A memory response arrives |
| rsp_wave_i | input | $clog2(NUM_SLOTS) | Slot the memory response belongs to |
| bubble_cnt_o | output | BUBBLE_W | Count of clocks whose turn had nothing to issue |

## Verification
Two pairs of functions can land on the same clock. The first pair is freeing a finished wavefront's registers and admitting a new one. The bench waits for the final group of a wavefront that fills the register file. On the very next clock, while that wavefront is DONE, it offers a zero-register admission. It then checks that a request of exactly the freed amount fits and one register more does not. The second pair is a position falling free and several wavefronts being ready at once. The ready sets are arranged so that the oldest candidate sits in a higher slot than a newer one, and the bench judges which slot fills the position first.

// File: rtl/wis_pkg.sv
package wis_pkg;

    typedef enum logic [2:0] {
        WS_EMPTY    = 3'd0,
        WS_READY    = 3'd1,
        WS_ISSUING  = 3'd2,
        WS_WAIT_MEM = 3'd3,
        WS_DONE     = 3'd4
    } wave_state_e;

endpackage

// File: rtl/wis_admit.sv
module wis_admit #(
    parameter int NUM_SLOTS = 8,
    parameter int RF_SIZE   = 256,
    parameter int GPR_W     = 9,
    parameter int SLOT_W    = 3
) (
    input  logic [NUM_SLOTS-1:0] empty_i,
    input  logic [GPR_W-1:0]     alloc_i,
    input  logic [GPR_W-1:0]     req_i,
    output logic                 ready_o,
    output logic [SLOT_W-1:0]    slot_o
);
    localparam int SUM_W = GPR_W + 1;

    logic             any_empty;
    logic [SUM_W-1:0] total;

    always_comb begin
        any_empty = 1'b0;
        slot_o    = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (empty_i[i]) begin
                any_empty = 1'b1;
                slot_o    = SLOT_W'(i);
            end
        end
        total   = {1'b0, alloc_i} + {1'b0, req_i};
        ready_o = any_empty && (total <= SUM_W'(RF_SIZE));
    end
endmodule

// File: rtl/wis_pick.sv
module wis_pick #(
    parameter int NUM_SLOTS = 8,
    parameter int TICKET_W  = 16,
    parameter int SLOT_W    = 3
) (
    input  logic [NUM_SLOTS-1:0]               ready_i,
    input  logic [NUM_SLOTS-1:0][TICKET_W-1:0] tkt_i,
    input  logic [TICKET_W-1:0]                now_i,
    output logic                               found_o,
    output logic [SLOT_W-1:0]                  idx_o
);
    logic [NUM_SLOTS-1:0][TICKET_W-1:0] age;

    // age since admission, modulo the ticket width
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_age
        assign age[g] = now_i - tkt_i[g];
    end

    logic [TICKET_W-1:0] best;

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        best    = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (ready_i[i] && (!found_o || age[i] > best)) begin
                found_o = 1'b1;
                idx_o   = SLOT_W'(i);
                best    = age[i];
            end
        end
    end
endmodule

// File: rtl/wave_issue_sched.sv
module wave_issue_sched
    import wis_pkg::*;
#(
    parameter int NUM_SLOTS    = 8,
    parameter int LANES        = 16,
    parameter int WAVE_THREADS = 64,
    parameter int RF_SIZE      = 256,
    parameter int TICKET_W     = 16,
    parameter int BUBBLE_W     = 16
) (
    input  logic                                         clk_i,
    input  logic                                         rst_ni,
    input  logic                                         adm_valid_i,
    output logic                                         adm_ready_o,
    input  logic [$clog2(RF_SIZE+1)-1:0]                 adm_gprs_i,
    output logic [$clog2(NUM_SLOTS)-1:0]                 adm_slot_o,
    output logic                                         iss_valid_o,
    output logic [$clog2(NUM_SLOTS)-1:0]                 iss_wave_o,
    output logic [$clog2(WAVE_THREADS/LANES)-1:0]        iss_group_o,
    input  logic                                         iss_mem_i,
    input  logic                                         iss_end_i,
    input  logic                                         rsp_valid_i,
    input  logic [$clog2(NUM_SLOTS)-1:0]                 rsp_wave_i,
    output logic [BUBBLE_W-1:0]                          bubble_cnt_o
);
    localparam int SLOT_W   = $clog2(NUM_SLOTS);
    localparam int GPR_W    = $clog2(RF_SIZE + 1);
    localparam int GROUPS   = WAVE_THREADS / LANES;
    localparam int GRP_W    = $clog2(GROUPS);
    localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(GROUPS - 1);

    typedef struct packed {
        wave_state_e [NUM_SLOTS-1:0]            st;
        logic [NUM_SLOTS-1:0][GPR_W-1:0]        gprs;
        logic [NUM_SLOTS-1:0][TICKET_W-1:0]     tkt;
        logic [TICKET_W-1:0]                    next_tkt;
        logic [GPR_W-1:0]                       alloc;
        logic                                   phase;
        logic [1:0]                             pos_busy;
        logic [1:0][SLOT_W-1:0]                 pos_wave;
        logic [1:0][GRP_W-1:0]                  pos_grp;
        logic [BUBBLE_W-1:0]                    bubbles;
    } sched_t;

    sched_t s_d, s_q;

    logic [NUM_SLOTS-1:0] empty_mask, ready_mask;
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_mask
        assign empty_mask[g] = (s_q.st[g] == WS_EMPTY);
        assign ready_mask[g] = (s_q.st[g] == WS_READY);
    end

    logic              pick_found;
    logic [SLOT_W-1:0] pick_idx;

    wis_admit #(
        .NUM_SLOTS(NUM_SLOTS), .RF_SIZE(RF_SIZE), .GPR_W(GPR_W), .SLOT_W(SLOT_W)
    ) admit_i (
        .empty_i(empty_mask), .alloc_i(s_q.alloc), .req_i(adm_gprs_i),
        .ready_o(adm_ready_o), .slot_o(adm_slot_o)
    );

    wis_pick #(
        .NUM_SLOTS(NUM_SLOTS), .TICKET_W(TICKET_W), .SLOT_W(SLOT_W)
    ) pick_i (
        .ready_i(ready_mask), .tkt_i(s_q.tkt), .now_i(s_q.next_tkt),
        .found_o(pick_found), .idx_o(pick_idx)
    );

    logic              adm_fire;
    logic              cur;
    logic              iss_v;
    logic [SLOT_W-1:0] iss_w;
    logic [GRP_W-1:0]  iss_g;
    logic [GPR_W-1:0]  rel;

    always_comb begin
        s_d      = s_q;
        adm_fire = adm_valid_i && adm_ready_o;
        cur      = s_q.phase;
        s_d.phase = ~s_q.phase;
        iss_v    = 1'b0;
        iss_w    = '0;
        iss_g    = '0;

        // turn of the current position: continue, refill or idle
        if (s_q.pos_busy[cur]) begin
            iss_v = 1'b1;
            iss_w = s_q.pos_wave[cur];
            iss_g = s_q.pos_grp[cur];
        end else if (pick_found) begin
            iss_v = 1'b1;
            iss_w = pick_idx;
            s_d.pos_busy[cur] = 1'b1;
            s_d.pos_wave[cur] = pick_idx;
            s_d.st[pick_idx]  = WS_ISSUING;
        end else begin
            s_d.bubbles = s_q.bubbles + 1'b1;
        end

        // lane-group sequencing and end-of-instruction outcome
        if (iss_v) begin
            if (iss_g == LAST_GRP) begin
                s_d.pos_grp[cur] = '0;
                if (iss_end_i) begin
                    s_d.st[iss_w]     = WS_DONE;
                    s_d.pos_busy[cur] = 1'b0;
                end else if (iss_mem_i) begin
                    s_d.st[iss_w]     = WS_WAIT_MEM;
                    s_d.pos_busy[cur] = 1'b0;
                end
            end else begin
                s_d.pos_grp[cur] = iss_g + 1'b1;
            end
        end

        // retire finished wavefronts
        rel = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (s_q.st[i] == WS_DONE) begin
                s_d.st[i]   = WS_EMPTY;
                s_d.gprs[i] = '0;
                rel         = rel + s_q.gprs[i];
            end
        end

        // memory response wakes only a waiting wavefront
        if (rsp_valid_i && s_q.st[rsp_wave_i] == WS_WAIT_MEM) begin
            s_d.st[rsp_wave_i] = WS_READY;
        end

        if (adm_fire) begin
            s_d.st[adm_slot_o]   = WS_READY;
            s_d.gprs[adm_slot_o] = adm_gprs_i;
            s_d.tkt[adm_slot_o]  = s_q.next_tkt;
            s_d.next_tkt         = s_q.next_tkt + 1'b1;
        end

        s_d.alloc = s_q.alloc + (adm_fire ? adm_gprs_i : GPR_W'(0)) - rel;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign iss_valid_o  = iss_v;
    assign iss_wave_o   = iss_w;
    assign iss_group_o  = iss_g;
    assign bubble_cnt_o = s_q.bubbles;

    // R2
    reg_budget_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.alloc <= GPR_W'(RF_SIZE));

    // R3
    admit_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adm_valid_i && adm_ready_o) |=> s_q.st[$past(adm_slot_o)] == WS_READY);

    // R4
    group_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (iss_valid_o && iss_group_o != LAST_GRP) |-> ##2
        (iss_valid_o && iss_wave_o == $past(iss_wave_o, 2) &&
         iss_group_o == GRP_W'($past(iss_group_o, 2) + 1'b1)));

    // R5
    distinct_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.pos_busy == 2'b11) |-> s_q.pos_wave[0] != s_q.pos_wave[1]);

    // R6
    no_stalled_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        iss_valid_o |-> (s_q.st[iss_wave_o] == WS_READY || s_q.st[iss_wave_o] == WS_ISSUING));

    // R9
    bubble_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !iss_valid_o |=> bubble_cnt_o == $past(bubble_cnt_o) + 1'b1);

    // R10
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_done_chk
        done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (s_q.st[g] == WS_DONE) |=> (s_q.st[g] == WS_EMPTY));
    end
endmodule

// File: tb/wave_issue_sched_tb_top.sv
module wave_issue_sched_tb_top;
    localparam int NS = 4;
    localparam int RF = 32;
    localparam int GW = $clog2(RF + 1);
    localparam int SW = $clog2(NS);

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          adm_valid_i = 1'b0;
    logic          adm_ready_o;
    logic [GW-1:0] adm_gprs_i = '0;
    logic [SW-1:0] adm_slot_o;
    logic          iss_valid_o;
    logic [SW-1:0] iss_wave_o;
    logic [1:0]    iss_group_o;
    logic          iss_mem_i, iss_end_i;
    logic          rsp_valid_i = 1'b0;
    logic [SW-1:0] rsp_wave_i = '0;
    logic [15:0]   bubble_cnt_o;
    logic [NS-1:0] mem_mask = '0;
    logic [NS-1:0] end_mask = '0;

    int checks = 0;
    int errors = 0;

    always #5 clk_i = ~clk_i;

    // instruction source model: flags only the last lane group
    assign iss_end_i = iss_valid_o && (iss_group_o == 2'd3) && end_mask[iss_wave_o];
    assign iss_mem_i = iss_valid_o && (iss_group_o == 2'd3) && mem_mask[iss_wave_o];

    wave_issue_sched #(
        .NUM_SLOTS(NS), .LANES(16), .WAVE_THREADS(64), .RF_SIZE(RF),
        .TICKET_W(16), .BUBBLE_W(16)
    ) dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .adm_valid_i(adm_valid_i), .adm_ready_o(adm_ready_o),
        .adm_gprs_i(adm_gprs_i), .adm_slot_o(adm_slot_o),
        .iss_valid_o(iss_valid_o), .iss_wave_o(iss_wave_o), .iss_group_o(iss_group_o),
        .iss_mem_i(iss_mem_i), .iss_end_i(iss_end_i),
        .rsp_valid_i(rsp_valid_i), .rsp_wave_i(rsp_wave_i),
        .bubble_cnt_o(bubble_cnt_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk_i);
        #1;
    endtask

    task automatic do_reset();
        rst_ni = 1'b0; adm_valid_i = 1'b0; adm_gprs_i = '0;
        rsp_valid_i = 1'b0; rsp_wave_i = '0; mem_mask = '0; end_mask = '0;
        repeat (3) tick();
        rst_ni = 1'b1;
    endtask

    task automatic admit(input int g, input int exp_slot);
        adm_gprs_i = GW'(g); adm_valid_i = 1'b1;
        #1;
        chk(adm_ready_o == 1'b1, "R2 admit ready", adm_ready_o, 1);
        chk(adm_slot_o == SW'(exp_slot), "R3 admit slot", adm_slot_o, exp_slot);
        tick();
        adm_valid_i = 1'b0;
    endtask

    task automatic wait_group3(input int w);
        for (int k = 0; k < 40; k++) begin
            if (iss_valid_o && iss_wave_o == SW'(w) && iss_group_o == 2'd3) break;
            tick();
        end
        chk(iss_valid_o && iss_wave_o == SW'(w) && iss_group_o == 2'd3,
            "R4 reach group 3", iss_wave_o, w);
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int b0, c0, c1, last_w;
        int prev_g [NS];

        // R1: reset state
        do_reset();
        rst_ni = 1'b0;
        #1;
        chk(iss_valid_o == 1'b0, "R1 idle in reset", iss_valid_o, 0);
        chk(bubble_cnt_o == 0, "R1 bubbles in reset", bubble_cnt_o, 0);
        chk(adm_ready_o && adm_slot_o == 0, "R1 admit slot 0", adm_slot_o, 0);
        tick();
        rst_ni = 1'b1;
        #1;
        chk(iss_valid_o == 1'b0 && bubble_cnt_o == 0, "R1 first cycle", bubble_cnt_o, 0);

        // R9: empty machine bubbles every clock
        repeat (10) tick();
        chk(bubble_cnt_o == 10, "R9 idle bubbles", bubble_cnt_o, 10);

        // R2: budget sweep on empty machine
        for (int r = 0; r <= 40; r++) begin
            adm_gprs_i = GW'(r);
            #1;
            chk(adm_ready_o == (r <= RF), "R2 budget sweep", adm_ready_o, int'(r <= RF));
        end

        // R4/R5/R9: two wavefronts interleaved
        do_reset();
        admit(4, 0);
        admit(4, 1);
        repeat (4) tick();
        b0 = bubble_cnt_o; c0 = 0; c1 = 0; last_w = -1;
        for (int i = 0; i < NS; i++) prev_g[i] = -1;
        for (int c = 0; c < 16; c++) begin
            chk(iss_valid_o == 1'b1, "R5 issue every clock", iss_valid_o, 1);
            if (last_w >= 0) chk(int'(iss_wave_o) != last_w, "R5 alternate", iss_wave_o, 1 - last_w);
            if (prev_g[iss_wave_o] >= 0)
                chk(int'(iss_group_o) == (prev_g[iss_wave_o] + 1) % 4, "R4 group order",
                    iss_group_o, (prev_g[iss_wave_o] + 1) % 4);
            prev_g[iss_wave_o] = iss_group_o;
            last_w = iss_wave_o;
            if (iss_wave_o == 0) c0++; else c1++;
            tick();
        end
        chk(c0 == 8 && c1 == 8, "R5 equal share", c0, 8);
        chk(int'(bubble_cnt_o) - b0 == 0, "R9 no bubbles when busy", int'(bubble_cnt_o) - b0, 0);

        // R2/R3/R8/R10: oldest ready fills a freed position
        do_reset();
        admit(2, 0); admit(2, 1); admit(2, 2); admit(2, 3);
        adm_gprs_i = '0;
        #1;
        chk(adm_ready_o == 1'b0, "R2 slots full", adm_ready_o, 0);
        end_mask[0] = 1'b1;
        for (int k = 0; k < 40; k++) begin
            if (iss_valid_o && (iss_wave_o == 2 || iss_wave_o == 3)) break;
            tick();
        end
        chk(iss_valid_o && iss_wave_o == 2, "R8 oldest of 2,3", iss_wave_o, 2);
        adm_gprs_i = GW'(2);
        #1;
        chk(adm_ready_o && adm_slot_o == 0, "R10 slot 0 freed", adm_slot_o, 0);
        end_mask[0] = 1'b0;
        admit(2, 0);
        end_mask[1] = 1'b1;
        for (int k = 0; k < 40; k++) begin
            if (iss_valid_o && (iss_wave_o == 0 || iss_wave_o == 3)) break;
            tick();
        end
        chk(iss_valid_o && iss_wave_o == 3, "R8 older slot 3 before newer slot 0", iss_wave_o, 3);

        // R6/R7: memory stall, stray response, wake-up
        do_reset();
        mem_mask[0] = 1'b1;
        admit(3, 0);
        wait_group3(0);
        tick();
        rsp_valid_i = 1'b1; rsp_wave_i = SW'(1);
        for (int k = 0; k < 12; k++) begin
            chk(iss_valid_o == 1'b0, "R6 stalled wave silent", iss_valid_o, 0);
            tick();
            rsp_valid_i = 1'b0;
        end
        adm_gprs_i = '0;
        #1;
        chk(adm_ready_o && adm_slot_o == 1, "R7 stray response ignored", adm_slot_o, 1);
        mem_mask[0] = 1'b0;
        rsp_valid_i = 1'b1; rsp_wave_i = SW'(0);
        tick();
        rsp_valid_i = 1'b0;
        chk(iss_valid_o && iss_wave_o == 0 && iss_group_o == 0, "R6 wake issues group 0",
            iss_valid_o, 1);

        // R11: release and admission on the same edge
        do_reset();
        end_mask[0] = 1'b1;
        admit(20, 0);
        admit(12, 1);
        adm_gprs_i = GW'(1);
        #1;
        chk(adm_ready_o == 1'b0, "R2 budget exhausted", adm_ready_o, 0);
        wait_group3(0);
        tick();
        adm_gprs_i = '0; adm_valid_i = 1'b1;
        #1;
        chk(adm_ready_o && adm_slot_o == 2, "R11 admit while releasing", adm_slot_o, 2);
        tick();
        adm_valid_i = 1'b0;
        adm_gprs_i = GW'(20);
        #1;
        chk(adm_ready_o == 1'b1, "R11 freed registers usable", adm_ready_o, 1);
        adm_gprs_i = GW'(21);
        #1;
        chk(adm_ready_o == 1'b0, "R11 one over budget", adm_ready_o, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule